// File: doc/BRIEF.md
# USB OUT Data-Packet Sender with Underrun Poisoning

This block sends the data field of one USB OUT packet to the link layer as a byte stream and then adds the CRC16. A start pulse carries the byte count and the number of byte times left before the micro-frame end. If the packet would not finish in that time, the block refuses to start it. Otherwise it pulls bytes from a source stream, passes them to the link and follows them with two CRC bytes.

The link pulls one byte each time it asserts `link_ready`. When that happens and the source has no byte to give, the block is in underrun. It raises a buffer-error flag and poisons the packet. Every remaining data slot carries a filler byte, so the packet keeps its planned length. The two CRC bytes are sent as the ones' complement of the correct CRC, so the device cannot take the packet for good data. An underrun is a buffer problem, not a transaction error, and the block signals nothing else for it.

Back-pressure rules:
- The source side is a valid/ready stream. A byte moves on a clock edge where `src_valid` and `src_ready` are both high.
- `src_ready` rises only in a data slot, only while `link_ready` is high and only while the packet is not poisoned.
- On the link side, a byte is taken on an edge where `tx_valid` and `link_ready` are both high.
- `tx_data` is meaningful only in such a cycle. While `link_ready` is low the block may swap a filler byte for a source byte that has just arrived.

Top module: `usb_out_sender`

## Requirements
- R1: Without underrun, the data bytes appear on `tx_data` in source order, one per accepted link transfer. A source byte is consumed only in the cycle its copy is accepted by the link.
- R2: After the data, two CRC bytes follow: low byte first, then high byte. The CRC uses polynomial x^16+x^15+x^2+1, is preset to 0xFFFF, processes each byte LSB first and is sent inverted (the nine ASCII bytes "123456789" give 0xC8 then 0xB4). `tx_last` is high only with the second CRC byte.
- R3: `done` is high for exactly one cycle, the cycle after the second CRC byte is accepted.
- R4: An underrun is an accepted link transfer in a data slot while `src_valid` is low. On an underrun the filler byte (0x00) is sent and `buf_err` rises.
- R5: After an underrun, every remaining data slot carries the filler byte and `src_ready` stays low. The packet still holds exactly byte count plus 2 bytes.
- R6: In a poisoned packet, both CRC bytes are the ones' complement of the correct inverted CRC of the bytes actually sent.
- R7: A start with byte count + 2 + OVERHEAD (4) greater than `time_left` gives a one-cycle `refused` pulse in the next cycle, and no byte is offered or consumed.
- R8: A start with byte count + 2 + OVERHEAD equal to `time_left` is accepted and sent in full.
- R9: A start pulse while a packet is in progress is ignored: no refusal pulse, and the length is unchanged.
- R10: `buf_err` stays high after the poisoned packet and clears when the next packet is accepted.
- R11: A byte count of zero sends only the two CRC bytes, 0x00 and 0x00.
- R12: While `link_ready` is low, no source byte is consumed and the packet does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send one packet |
| byte_cnt | input | 11 | Data byte count, sampled with start |
| time_left | input | 13 | Byte times left before micro-frame end, sampled with start |
| src_data | input | 8 | Source byte |
| src_valid | input | 1 | Source byte present |
| src_ready | output | 1 | Source byte taken this cycle |
| tx_data | output | 8 | Byte to the link layer |
| tx_valid | output | 1 | Byte offered to the link |
| tx_last | output | 1 | Final byte of the packet |
| link_ready | input | 1 | Link takes a byte this cycle |
| buf_err | output | 1 | Data buffer error (underrun) seen |
| refused | output | 1 | Start refused for lack of time |
| done | output | 1 | Packet finished |

## Verification
The main path is tried with a known nine-byte vector whose CRC is fixed, with a link that stalls every third cycle, and with a zero-length packet. Together they separate byte order, CRC bit order and byte order, and stall handling. Underruns are placed at the first, a middle and the last data byte. This shows whether the filler covers every later slot and whether the complemented CRC is applied even when the fault arrives just before the CRC phase. The time check is driven at one byte time short and at an exact fit, which separates a correct comparison from an off-by-one. A start inside a running packet shows whether a busy sender ignores it.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_CRC_LO = 2'd2,
    ST_CRC_HI = 2'd3
  } tx_state_t;

  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'hA001;
endpackage

// File: rtl/usbtx_crc16.sv
module usbtx_crc16
  import usbtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        enable,
  input  logic [7:0]  din,
  output logic [15:0] rem
);
  logic [15:0] nxt;

  always_comb begin
    nxt = rem;
    for (int b = 0; b < 8; b++) begin
      if (nxt[0] ^ din[b]) nxt = (nxt >> 1) ^ CRC_POLY_R;
      else                 nxt = nxt >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) rem <= CRC_PRESET;
    else if (enable)     rem <= nxt;
  end
endmodule

// File: rtl/usbtx_budget.sv
module usbtx_budget #(
  parameter int CNT_W    = 11,
  parameter int TIME_W   = 13,
  parameter int OVERHEAD = 4
) (
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [TIME_W-1:0] time_left,
  output logic              fits
);
  localparam int SUM_W = ((CNT_W > TIME_W) ? CNT_W : TIME_W) + 2;

  logic [SUM_W-1:0] need;
  assign need = SUM_W'(byte_cnt) + SUM_W'(2 + OVERHEAD);
  assign fits = need <= SUM_W'(time_left);
endmodule

// File: rtl/usbtx_seq.sv
module usbtx_seq
  import usbtx_pkg::*;
#(
  parameter int          CNT_W = 11,
  parameter logic [7:0]  FILL  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fits,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [7:0]       src_data,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [15:0]      crc_rem,
  output logic             crc_clear,
  output logic             crc_en,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  input  logic             link_ready,
  output logic             buf_err,
  output logic             refused,
  output logic             done
);
  tx_state_t        state;
  logic [CNT_W-1:0] remain;
  logic             poison;
  logic             take_start, fire, underrun;
  logic [15:0]      crc_tx;

  assign take_start = (state == ST_IDLE) && start && fits;
  assign fire       = tx_valid && link_ready;
  assign underrun   = (state == ST_DATA) && link_ready && !poison && !src_valid;
  assign crc_tx     = poison ? crc_rem : ~crc_rem;
  assign crc_clear  = take_start;
  assign crc_en     = fire && (state == ST_DATA);

  always_comb begin
    tx_valid  = 1'b0;
    tx_last   = 1'b0;
    tx_data   = 8'h00;
    src_ready = 1'b0;
    unique case (state)
      ST_DATA: begin
        tx_valid  = 1'b1;
        src_ready = link_ready && !poison;
        tx_data   = (poison || !src_valid) ? FILL : src_data;
      end
      ST_CRC_LO: begin
        tx_valid = 1'b1;
        tx_data  = crc_tx[7:0];
      end
      ST_CRC_HI: begin
        tx_valid = 1'b1;
        tx_last  = 1'b1;
        tx_data  = crc_tx[15:8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      remain  <= '0;
      poison  <= 1'b0;
      buf_err <= 1'b0;
      refused <= 1'b0;
      done    <= 1'b0;
    end else begin
      refused <= (state == ST_IDLE) && start && !fits;
      done    <= (state == ST_CRC_HI) && fire;
      unique case (state)
        ST_IDLE: if (take_start) begin
          remain  <= byte_cnt;
          poison  <= 1'b0;
          buf_err <= 1'b0;
          state   <= (byte_cnt == '0) ? ST_CRC_LO : ST_DATA;
        end
        ST_DATA: if (fire) begin
          if (underrun) begin
            poison  <= 1'b1;
            buf_err <= 1'b1;
          end
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= ST_CRC_LO;
        end
        ST_CRC_LO: if (fire) state <= ST_CRC_HI;
        ST_CRC_HI: if (fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_out_sender.sv
module usb_out_sender #(
  parameter int         CNT_W    = 11,
  parameter int         TIME_W   = 13,
  parameter int         OVERHEAD = 4,
  parameter logic [7:0] FILL     = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [TIME_W-1:0] time_left,
  input  logic [7:0]        src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              link_ready,
  output logic              buf_err,
  output logic              refused,
  output logic              done
);
  logic        fits, crc_clear, crc_en;
  logic [15:0] crc_rem;

  usbtx_budget #(.CNT_W(CNT_W), .TIME_W(TIME_W), .OVERHEAD(OVERHEAD)) u_budget (
    .byte_cnt (byte_cnt),
    .time_left(time_left),
    .fits     (fits)
  );

  usbtx_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (crc_clear),
    .enable(crc_en),
    .din   (tx_data),
    .rem   (crc_rem)
  );

  usbtx_seq #(.CNT_W(CNT_W), .FILL(FILL)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fits      (fits),
    .byte_cnt  (byte_cnt),
    .src_data  (src_data),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .crc_rem   (crc_rem),
    .crc_clear (crc_clear),
    .crc_en    (crc_en),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .link_ready(link_ready),
    .buf_err   (buf_err),
    .refused   (refused),
    .done      (done)
  );
endmodule

// File: rtl/usb_out_sender_chk.sv
module usb_out_sender_chk (
  input logic clk,
  input logic rst_n,
  input logic src_valid,
  input logic src_ready,
  input logic tx_valid,
  input logic tx_last,
  input logic link_ready,
  input logic buf_err,
  input logic refused,
  input logic done
);
  // R12
  src_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> link_ready);

  // R2
  last_is_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tx_valid && tx_last && link_ready));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  poisoned_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_err |-> !src_ready);

  // R4
  err_from_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_err) |-> $past(tx_valid && link_ready && !src_valid));

  // R7
  refused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> !tx_valid);

  // R12
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !link_ready) |=> tx_valid);
endmodule

bind usb_out_sender usb_out_sender_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .tx_valid  (tx_valid),
  .tx_last   (tx_last),
  .link_ready(link_ready),
  .buf_err   (buf_err),
  .refused   (refused),
  .done      (done)
);

// File: tb/usb_out_sender_test.sv
module usb_out_sender_test;
  localparam int OH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] byte_cnt = '0;
  logic [12:0] time_left = '0;
  logic [7:0]  src_data = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last;
  logic        link_ready = 1'b0;
  logic        buf_err, refused, done;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] mem [0:63];
  logic [7:0] got [0:70];
  logic       gotl[0:70];

  always #4 clk = ~clk;

  usb_out_sender uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .time_left(time_left), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .link_ready(link_ready), .buf_err(buf_err),
    .refused(refused), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ got[i][b]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return ~c;
  endfunction

  // Sends one packet of n bytes from mem. gap: index of the byte the source
  // withholds (-1 = none). stall: link idles every stall-th cycle (0 = never).
  // poke: extra start pulse mid-packet. tl: time left given with start.
  task automatic run(input int n, input int gap, input int stall, input bit poke, input int tl);
    int  k = 0, si = 0, cyc = 0, bad_src = 0, bad_ref = 0;
    bit  gapdone = 0, fin = 0;
    logic [15:0] crc;
    @(negedge clk);
    start = 1; byte_cnt = 11'(n); time_left = 13'(tl);
    @(negedge clk);
    start = 0;
    chk(buf_err == 0, "R10 buf_err cleared by accepted start", int'(buf_err), 0);
    while (!fin && cyc < 400) begin
      link_ready = !(stall > 0 && (cyc % stall) == stall - 1);
      src_valid  = (si < n) && !(si == gap && !gapdone);
      src_data   = mem[si % 64];
      start      = poke && cyc == 2;
      byte_cnt   = poke && cyc == 2 ? 11'd1 : 11'(n);
      #1;
      if (src_ready && !link_ready) bad_src++;
      if (src_ready && gapdone) bad_src++;
      if (refused) bad_ref++;
      if (tx_valid && link_ready) begin
        if (k <= 70) begin got[k] = tx_data; gotl[k] = tx_last; end
        k++;
        if (tx_last) fin = 1;
      end
      if (src_valid && src_ready) si++;
      if (si == gap && !src_valid && link_ready && tx_valid && k <= n) gapdone = 1;
      cyc++;
      @(negedge clk);
      start = 0;
    end
    link_ready = 0; src_valid = 0;
    chk(fin, "R1 packet completes", fin, 1);
    chk(k == n + 2, "R5 packet length", k, n + 2);
    for (int i = 0; i < n && i < k; i++) begin
      logic [7:0] e = (gap >= 0 && i >= gap) ? 8'h00 : mem[i];
      if (got[i] !== e) begin
        chk(0, (gap >= 0 && i >= gap) ? "R5 filler byte" : "R1 data byte", got[i], e);
        break;
      end
    end
    crc = crc_of(n);
    if (gap >= 0 && gap < n) crc = ~crc;
    if (k == n + 2) begin
      chk(got[n] == crc[7:0] && got[n+1] == crc[15:8],
          (gap >= 0 && gap < n) ? "R6 complemented CRC" : "R2 CRC bytes",
          {got[n+1], got[n]}, crc);
      for (int i = 0; i < k; i++)
        if (gotl[i] !== (i == k - 1)) begin
          chk(0, "R2 tx_last placement", i, k - 1);
          break;
        end
    end
    chk(bad_src == 0, "R12 R5 source consumed wrongly", bad_src, 0);
    chk(bad_ref == 0, "R9 no refusal while busy", bad_ref, 0);
    chk(done == 1, "R3 done after last byte", done, 1);
    chk(buf_err == (gap >= 0 && gap < n), "R4 buf_err", buf_err, (gap >= 0 && gap < n));
    @(negedge clk);
    chk(done == 0, "R3 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!tx_valid && !src_ready && !buf_err && !refused && !done, "R3 R7 reset outputs",
        {tx_valid, src_ready, buf_err, refused, done}, 0);
  endtask

  task automatic t_vector();
    string s = "123456789";
    for (int i = 0; i < 9; i++) mem[i] = s[i];
    run(9, -1, 0, 0, 100);
    chk(got[9] == 8'hC8 && got[10] == 8'hB4, "R2 known vector", {got[10], got[9]}, 16'hB4C8);
  endtask

  task automatic t_stalled();
    for (int i = 0; i < 20; i++) mem[i] = 8'(i * 37 + 5);
    run(20, -1, 3, 0, 100);
  endtask

  task automatic t_under_mid();
    for (int i = 0; i < 12; i++) mem[i] = 8'(8'hA0 + i);
    run(12, 5, 0, 0, 100);
    repeat (3) @(negedge clk);
    chk(buf_err == 1, "R10 buf_err held after packet", buf_err, 1);
  endtask

  task automatic t_under_edges();
    run(6, 0, 0, 0, 100);
    run(6, 5, 4, 0, 100);
  endtask

  task automatic t_zero();
    run(0, -1, 0, 0, 100);
    chk(got[0] == 8'h00 && got[1] == 8'h00, "R11 zero length CRC", {got[1], got[0]}, 0);
  endtask

  task automatic t_refuse();
    int seen = 0;
    @(negedge clk);
    start = 1; byte_cnt = 11'd10; time_left = 13'(10 + 2 + OH - 1);
    link_ready = 1; src_valid = 1;
    @(negedge clk);
    start = 0;
    chk(refused == 1, "R7 refused pulse", refused, 1);
    for (int i = 0; i < 4; i++) begin
      if (tx_valid || src_ready) seen++;
      @(negedge clk);
      if (i == 0) chk(refused == 0, "R7 refused one cycle", refused, 0);
    end
    chk(seen == 0, "R7 nothing sent when refused", seen, 0);
    link_ready = 0; src_valid = 0;
  endtask

  task automatic t_exact();
    for (int i = 0; i < 10; i++) mem[i] = 8'(8'h11 * i);
    run(10, -1, 0, 0, 10 + 2 + OH);
    chk(refused == 0, "R8 exact fit not refused", refused, 0);
  endtask

  task automatic t_busy();
    for (int i = 0; i < 8; i++) mem[i] = 8'(8'h5A ^ i);
    run(8, -1, 0, 1, 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_vector();
    t_stalled();
    t_under_mid();
    t_exact();
    t_under_edges();
    t_zero();
    t_refuse();
    t_busy();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule